// File: doc/BRIEF.md
# JTAG Identification Word Reader

This block is a host-side engine that connects to the test access port of a single target device and reads back its 32-bit identification word. A system clock is divided down to make the test clock. On a start request the engine first pulls the optional test reset line low. It then plays out a fixed mode-select pattern that parks the target in Test-Logic-Reset and loads the identification instruction through the instruction path. Finally it walks into the data shift state and clocks the 32-bit word out of the target's serial data output.

When the last bit arrives the captured word is held on a parallel output and a completion flag rises. A sticky error flag reports a word whose mandatory marker bit (bit 0) is not set. An 8-bit display bus then pages the word out one byte at a time, most significant byte first, each byte for a programmable hold time, and returns to a fixed idle pattern afterwards. The block is meant to sit beside a small board-bring-up controller. Software or a button pulses `start`, and a row of indicators or a logic analyser watches the byte bus.

Top module: `jtag_id_reader`

## Requirements
- R1: After reset, `tck` is 0, `tms` is 1, `trst_n` is 1, `done` and `err` are 0, `id_word` is 0 and `disp` shows the idle pattern `IDLE_BYTE`.
- R2: During a run each high phase of `tck` lasts exactly `HALF_DIV` system clocks, and a run produces exactly 55 rising edges of `tck`. Outside a run `tck` stays low.
- R3: A run begins with `trst_n` low for exactly 2*`HALF_DIV` system clocks, during which `tck` stays low, before the first `tck` rising edge.
- R4: `tms` changes only in the system clock in which `tck` rises. Seen by the target on its rising edges, the pattern is: six 1s (the idle level plus five reset bits), then 0, 1, 1, 0, 0, which reaches Shift-IR.
- R5: The 4-bit instruction 0x1 is shifted in least significant bit first. `tdi` is 1 on the first instruction bit and 0 on the other three, and `tms` is 0,0,0,1 on those four edges. Then `tms` is 1, 1, 0, 0, which reaches Shift-DR, so the target's instruction register holds 0x1 after Update-IR.
- R6: `tdo` is sampled when `tck` falls. Exactly 32 data bits are taken, the first received bit ending up in `id_word[0]`. The last data shift carries `tms`=1, and four more 1s then return the target to Test-Logic-Reset.
- R7: `done` rises once the 32nd bit is captured and stays high, with `id_word` holding the value, until the next accepted start. An accepted start clears `done`.
- R8: `err` is set when a captured word has bit 0 equal to 0. It stays set across later good runs and only reset clears it.
- R9: A `start` pulse during a run is ignored: no second reset pulse, no extra edges, and the word is unchanged.
- R10: After capture, `disp` shows byte 3, byte 2, byte 1 and then byte 0 of the word, each for `HOLD_CYCLES` system clocks, and then returns to `IDLE_BYTE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one readout (ignored while busy) |
| tdo | input | 1 | Serial data from the target |
| tck | output | 1 | Divided test clock, idles low |
| tms | output | 1 | Mode select to the target |
| tdi | output | 1 | Serial data to the target |
| trst_n | output | 1 | Active-low test reset to the target |
| id_word | output | 32 | Captured identification word |
| done | output | 1 | Capture complete |
| err | output | 1 | Sticky: a captured word lacked its bit-0 marker |
| disp | output | 8 | Byte-paged view of the word, idle pattern otherwise |

## Verification
The bench holds a behavioural target TAP and tries the reader against several identification words. A mixed-nibble word exposes bit ordering and byte paging order. Words with only the top bit set, or with all but the top bit set, separate LSB-first capture from MSB-first capture and catch an off-by-one in the shift count. An alternating pattern with bit 0 cleared sets the error flag, and the good word read after it shows that the flag is sticky. A start pulse injected mid-run shows that busy starts are ignored. The target model records the mode-select bits it saw and its final state, which checks the whole TAP path and the return to reset independently of the reader's internals.

// File: rtl/jid_pkg.sv
package jid_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_TRST = 2'd1,
      SQ_RUN  = 2'd2
   } sq_state_t;
endpackage

// File: rtl/jid_tick.sv
module jid_tick #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

   logic [CW-1:0] cnt;

   assign tick = en && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (!en)      cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else               cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/jid_seq.sv
module jid_seq
   import jid_pkg::*;
#(
   parameter int              RESET_LEN = 5,
   parameter int              IR_W      = 4,
   parameter int              DR_W      = 32,
   parameter logic [IR_W-1:0] INSTR     = 4'h1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            tick,
   input  logic            tdo,
   output logic            run_en,
   output logic            tck,
   output logic            tms,
   output logic            tdi,
   output logic            trst_n,
   output logic [DR_W-1:0] shreg,
   output logic            done,
   output logic            cap_pulse,
   output logic            err
);
   // rise index layout of one readout
   localparam int IR_S  = RESET_LEN + 5;
   localparam int IR_L  = IR_S + IR_W - 1;
   localparam int DR_S  = IR_L + 5;
   localparam int DR_L  = DR_S + DR_W - 1;
   localparam int NRISE = DR_L + 6;
   localparam int RW    = $clog2(NRISE + 1);

   sq_state_t     st;
   logic [RW-1:0] rcnt;
   logic          trst_half;
   int            rc;

   function automatic logic tms_at(input int c);
      if (c < RESET_LEN)           return 1'b1;
      else if (c == RESET_LEN)     return 1'b0;
      else if (c <= RESET_LEN + 2) return 1'b1;
      else if (c < IR_L)           return 1'b0;
      else if (c <= IR_L + 2)      return 1'b1;
      else if (c < DR_L)           return 1'b0;
      else                         return 1'b1;
   endfunction

   function automatic logic tdi_at(input int c);
      logic [IR_W-1:0] sh;
      if (c < IR_S || c > IR_L) return 1'b0;
      sh = INSTR >> (c - IR_S);
      return sh[0];
   endfunction

   assign rc     = int'(rcnt);
   assign run_en = (st != SQ_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= SQ_IDLE;
         rcnt      <= '0;
         trst_half <= 1'b0;
         tck       <= 1'b0;
         tms       <= 1'b1;
         tdi       <= 1'b0;
         trst_n    <= 1'b1;
         shreg     <= '0;
         done      <= 1'b0;
         cap_pulse <= 1'b0;
      end else begin
         cap_pulse <= 1'b0;
         case (st)
            SQ_IDLE: if (start) begin
               st        <= SQ_TRST;
               trst_n    <= 1'b0;
               trst_half <= 1'b0;
               rcnt      <= '0;
               tms       <= 1'b1;
               shreg     <= '0;
               done      <= 1'b0;
            end
            SQ_TRST: if (tick) begin
               trst_half <= 1'b1;
               if (trst_half) begin
                  trst_n <= 1'b1;
                  st     <= SQ_RUN;
               end
            end
            SQ_RUN: if (tick) begin
               if (!tck) begin
                  tck  <= 1'b1;
                  tms  <= tms_at(rc);
                  tdi  <= tdi_at(rc);
                  rcnt <= rcnt + 1'b1;
               end else begin
                  tck <= 1'b0;
                  if (rc >= DR_S + 1 && rc <= DR_L + 1)
                     shreg <= {tdo, shreg[DR_W-1:1]};
                  if (rc == DR_L + 1) begin
                     done      <= 1'b1;
                     cap_pulse <= 1'b1;
                  end
                  if (rc == NRISE) st <= SQ_IDLE;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      err <= 1'b0;
      else if (cap_pulse && !shreg[0]) err <= 1'b1;
   end

   p_tck_low_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st != SQ_RUN) |-> !tck);
   p_tck_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_RUN && !tick) |=> $stable(tck));
   p_trst_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !trst_n |-> !tck);
   p_tms_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tms) |-> $rose(tck));
   p_shift_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_RUN && !$stable(shreg)) |-> $fell(tck));
   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
   p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_RUN && start) |=> (st != SQ_TRST));
endmodule

// File: rtl/jid_pager.sv
module jid_pager #(
   parameter int         DR_W        = 32,
   parameter int         HOLD_CYCLES = 50_000_000,
   parameter logic [7:0] IDLE_BYTE   = 8'h00,
   parameter bit         MSB_FIRST   = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [DR_W-1:0] word,
   output logic [7:0]      disp
);
   localparam int NB    = DR_W / 8;
   localparam int IW    = $clog2(NB);
   localparam int HW    = $clog2(HOLD_CYCLES);
   localparam int FIRST = MSB_FIRST ? NB - 1 : 0;

   logic [DR_W-1:0] wreg;
   logic            active;
   logic [IW-1:0]   idx;
   logic [IW-1:0]   sel;
   logic [HW-1:0]   hcnt;

   generate
      if (MSB_FIRST) begin : g_msb
         assign sel = IW'(NB - 1) - idx;
      end else begin : g_lsb
         assign sel = idx;
      end
   endgenerate

   assign disp = active ? wreg[{sel, 3'b000} +: 8] : IDLE_BYTE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wreg   <= '0;
         active <= 1'b0;
         idx    <= '0;
         hcnt   <= '0;
      end else if (load) begin
         wreg   <= word;
         active <= 1'b1;
         idx    <= '0;
         hcnt   <= '0;
      end else if (active) begin
         if (hcnt == HW'(HOLD_CYCLES - 1)) begin
            hcnt <= '0;
            if (idx == IW'(NB - 1)) active <= 1'b0;
            else                    idx    <= idx + 1'b1;
         end else begin
            hcnt <= hcnt + 1'b1;
         end
      end
   end

   p_first_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (disp == $past(word[FIRST*8 +: 8])));
   p_hold_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !load && hcnt != HW'(HOLD_CYCLES - 1)) |=> $stable(disp));
endmodule

// File: rtl/jtag_id_reader.sv
module jtag_id_reader #(
   parameter int         HALF_DIV    = 4,
   parameter int         HOLD_CYCLES = 50_000_000,
   parameter logic [7:0] IDLE_BYTE   = 8'h00,
   parameter bit         MSB_FIRST   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        tdo,
   output logic        tck,
   output logic        tms,
   output logic        tdi,
   output logic        trst_n,
   output logic [31:0] id_word,
   output logic        done,
   output logic        err,
   output logic [7:0]  disp
);
   localparam int              DR_W      = 32;
   localparam int              IR_W      = 4;
   localparam int              RESET_LEN = 5;
   localparam logic [IR_W-1:0] INSTR     = 4'h1;

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (HOLD_CYCLES < 2) begin : g_bad_hold
         $error("HOLD_CYCLES must be at least 2");
      end
      if (DR_W % 8 != 0) begin : g_bad_width
         $error("word width must be whole bytes");
      end
   endgenerate

   logic run_en;
   logic tick;
   logic cap_pulse;

   jid_tick #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (run_en),
      .tick  (tick)
   );

   jid_seq #(
      .RESET_LEN (RESET_LEN),
      .IR_W      (IR_W),
      .DR_W      (DR_W),
      .INSTR     (INSTR)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .tick      (tick),
      .tdo       (tdo),
      .run_en    (run_en),
      .tck       (tck),
      .tms       (tms),
      .tdi       (tdi),
      .trst_n    (trst_n),
      .shreg     (id_word),
      .done      (done),
      .cap_pulse (cap_pulse),
      .err       (err)
   );

   jid_pager #(
      .DR_W        (DR_W),
      .HOLD_CYCLES (HOLD_CYCLES),
      .IDLE_BYTE   (IDLE_BYTE),
      .MSB_FIRST   (MSB_FIRST)
   ) u_pager (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (cap_pulse),
      .word  (id_word),
      .disp  (disp)
   );

   p_done_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> $stable(id_word));
endmodule

// File: tb/jtag_id_reader_tb.sv
module jtag_id_reader_tb;
   localparam int         CLK_PERIOD = 10;
   localparam int         HD         = 3;
   localparam int         HOLD       = 16;
   localparam logic [7:0] IDLE       = 8'hC6;
   localparam int         WD_LIMIT   = 100000;
   localparam int         NV         = 5;
   localparam logic [31:0] V_ID [NV] = '{32'h4960_A03F, 32'h8000_0001,
                                         32'h7FFF_FFFF, 32'h2AAA_5554,
                                         32'h0951_103F};
   localparam bit          V_MID [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        tdo;
   logic        tck, tms, tdi, trst_n, done, err;
   logic [31:0] id_word;
   logic [7:0]  disp;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   jtag_id_reader #(.HALF_DIV(HD), .HOLD_CYCLES(HOLD), .IDLE_BYTE(IDLE)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .tdo(tdo), .tck(tck), .tms(tms),
      .tdi(tdi), .trst_n(trst_n), .id_word(id_word), .done(done), .err(err),
      .disp(disp)
   );

   // ---------------- behavioural target TAP ----------------
   typedef enum logic [3:0] {T_TLR, T_RTI, T_SDR, T_CDR, T_SHDR, T_E1DR, T_PDR,
      T_E2DR, T_UDR, T_SIR, T_CIR, T_SHIR, T_E1IR, T_PIR, T_E2IR, T_UIR} tap_t;

   tap_t        ts = T_TLR;
   logic        tms_l = 1'b1;
   logic        tdi_l = 1'b0;
   logic [3:0]  ir_sh = 4'h0;
   logic [3:0]  ir_q = 4'hF;
   logic [31:0] dr_sh = 32'h0;
   logic [31:0] tgt_id = 32'h0;
   logic [63:0] tms_vec = 64'h0;
   int          rise_b = 0;
   int          shift_b = 0;
   int          base_rise = 0;

   function automatic tap_t tap_next(input tap_t s, input logic m);
      case (s)
         T_TLR:  return m ? T_TLR  : T_RTI;
         T_RTI:  return m ? T_SDR  : T_RTI;
         T_SDR:  return m ? T_SIR  : T_CDR;
         T_CDR:  return m ? T_E1DR : T_SHDR;
         T_SHDR: return m ? T_E1DR : T_SHDR;
         T_E1DR: return m ? T_UDR  : T_PDR;
         T_PDR:  return m ? T_E2DR : T_PDR;
         T_E2DR: return m ? T_UDR  : T_SHDR;
         T_UDR:  return m ? T_SDR  : T_RTI;
         T_SIR:  return m ? T_TLR  : T_CIR;
         T_CIR:  return m ? T_E1IR : T_SHIR;
         T_SHIR: return m ? T_E1IR : T_SHIR;
         T_E1IR: return m ? T_UIR  : T_PIR;
         T_PIR:  return m ? T_E2IR : T_PIR;
         T_E2IR: return m ? T_UIR  : T_SHIR;
         default: return m ? T_SDR : T_RTI;
      endcase
   endfunction

   always @(negedge tck) begin
      tms_l <= tms;
      tdi_l <= tdi;
   end

   always @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ts <= T_TLR;
      end else begin
         case (ts)
            T_CIR:  ir_sh <= 4'b0001;
            T_SHIR: ir_sh <= {tdi_l, ir_sh[3:1]};
            T_UIR:  ir_q  <= ir_sh;
            T_CDR:  dr_sh <= tgt_id;
            T_SHDR: begin
               dr_sh   <= {tdi_l, dr_sh[31:1]};
               shift_b <= shift_b + 1;
            end
            default: ;
         endcase
         if (rise_b - base_rise >= 0 && rise_b - base_rise < 64)
            tms_vec[rise_b - base_rise] <= tms_l;
         rise_b <= rise_b + 1;
         ts     <= tap_next(ts, tms_l);
      end
   end

   assign tdo = (ts == T_SHDR) ? dr_sh[0] : (ts == T_SHIR) ? ir_sh[0] : 1'b0;

   // ---------------- port monitors ----------------
   logic tck_p = 1'b0;
   logic tms_p = 1'b1;
   int   hi_run = 0;
   int   hi_bad = 0;
   int   tms_bad = 0;
   int   trst_low = 0;
   int   trst_tck = 0;

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (rst_n) begin
         if (tms !== tms_p && !(tck && !tck_p)) tms_bad <= tms_bad + 1;
         if (tck) hi_run <= hi_run + 1;
         else if (hi_run != 0) begin
            if (hi_run != HD) hi_bad <= hi_bad + 1;
            hi_run <= 0;
         end
         if (!trst_n) begin
            trst_low <= trst_low + 1;
            if (tck) trst_tck <= trst_tck + 1;
         end
      end
      tck_p <= tck;
      tms_p <= tms;
   end

   // ---------------- checking helpers ----------------
   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // mode-select bit the target should see on its r-th rising edge of a run
   function automatic logic exp_tms(input int r);
      if (r <= 5)  return 1'b1;   // idle level + five reset bits
      if (r == 6)  return 1'b0;   // Run-Test/Idle
      if (r <= 8)  return 1'b1;   // Select-DR, Select-IR
      if (r <= 13) return 1'b0;   // Capture-IR, Shift-IR, 3 instr bits
      if (r <= 16) return 1'b1;   // last instr bit, Update-IR, Select-DR
      if (r <= 49) return 1'b0;   // Capture-DR, Shift-DR, 31 data bits
      return 1'b1;                // last data bit and return to reset
   endfunction

   logic err_exp = 1'b0;

   task automatic run_one(input logic [31:0] id, input bit mid);
      int s_hi, s_tms, s_tl, s_tt, s_sh, m, t;
      logic [54:0] exp_v;
      tgt_id = id;
      base_rise = rise_b;
      s_hi = hi_bad; s_tms = tms_bad; s_tl = trst_low; s_tt = trst_tck; s_sh = shift_b;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(!done, "R7", "done cleared by start", 64'(done), 64'd0);
      if (mid) begin
         repeat (100) @(negedge clk);
         start = 1'b1;
         @(negedge clk) start = 1'b0;
      end
      while (!done && cyc < WD_LIMIT) @(negedge clk);
      chk(done, "R7", "done after capture", 64'(done), 64'd1);
      chk(id_word == id, "R6", "captured word", 64'(id_word), 64'(id));
      m = 0;
      for (int k = 0; k < 4; k++) begin
         t = 1 + k * HOLD + HOLD / 2;
         repeat (t - m) @(negedge clk);
         m = t;
         chk(disp == id[31 - 8*k -: 8], "R10", $sformatf("byte %0d", k),
             64'(disp), 64'(id[31 - 8*k -: 8]));
      end
      repeat (4 * HOLD + 2 - m) @(negedge clk);
      chk(disp == IDLE, "R10", "idle after paging", 64'(disp), 64'(IDLE));
      chk(done && id_word == id, "R7", "word held", 64'(id_word), 64'(id));
      err_exp = err_exp | ~id[0];
      chk(err == err_exp, "R8", "error flag", 64'(err), 64'(err_exp));
      chk(rise_b - base_rise == 55, "R2", "tck rises", 64'(rise_b - base_rise), 64'd55);
      chk(hi_bad == s_hi, "R2", "tck high width", 64'(hi_bad - s_hi), 64'd0);
      chk(!tck, "R2", "tck idle low", 64'(tck), 64'd0);
      chk(trst_low - s_tl == 2 * HD, mid ? "R9" : "R3", "trst low clocks",
          64'(trst_low - s_tl), 64'(2 * HD));
      chk(trst_tck == s_tt, "R3", "tck quiet in trst", 64'(trst_tck - s_tt), 64'd0);
      chk(tms_bad == s_tms, "R4", "tms changes off rise", 64'(tms_bad - s_tms), 64'd0);
      for (int r = 0; r < 55; r++) exp_v[r] = exp_tms(r);
      chk(tms_vec[54:0] == exp_v, "R4", "tms pattern", 64'(tms_vec[54:0]), 64'(exp_v));
      chk(ir_q == 4'h1, "R5", "instruction loaded", 64'(ir_q), 64'h1);
      chk(shift_b - s_sh == 32, "R6", "data shifts", 64'(shift_b - s_sh), 64'd32);
      chk(ts == T_TLR, "R6", "target back in reset", 64'(ts), 64'(T_TLR));
   endtask

   task automatic check_reset_state();
      chk(!tck && tms && trst_n, "R1", "tck/tms/trst_n", {61'd0, tck, tms, trst_n}, 64'b011);
      chk(!done && !err, "R1", "done/err", {62'd0, done, err}, 64'd0);
      chk(id_word == 32'h0, "R1", "id_word", 64'(id_word), 64'd0);
      chk(disp == IDLE, "R1", "disp idle", 64'(disp), 64'(IDLE));
   endtask

   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_reset_state();
      // table of words walked by one loop; entry 1 injects a busy start (R9)
      for (int i = 0; i < NV; i++) run_one(V_ID[i], V_MID[i]);
      // directed: reset clears sticky error and restores idle state
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      err_exp = 1'b0;
      @(negedge clk);
      check_reset_state();
      run_one(32'hC3A5_5A3D, 1'b0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule